// File: doc/BRIEF.md
# Misprediction Tolerant Branch Resolver

This block resolves confidence branches that guard value-speculative code. A confidence branch is taken when the value prediction proved wrong and not taken when it proved right. The taken target is the fixup code, which recomputes with the non-speculative value and is therefore correct in every case. Each resolution arrives on a one-cycle valid strobe. The strobe carries the predicted direction, the resolved direction, a tolerant flag, the branch address and both candidate fetch targets.

Ordinary branches recover on any direction mismatch. They raise a flush and supply the target of the resolved direction. Tolerant branches skip recovery in one case: fetch went down the fixup path, but the value turned out to be right. The work already fetched there is still correct, so no flush is needed. Each skipped recovery is counted in a saturating statistics counter.

Every resolution also issues a training update with the resolved direction, so the direction tables keep learning confidence. All outputs are registered and appear on the clock edge after the strobe.

Top module: `tolerant_branch_resolver`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `flush`, `redirect_pc`, `train_valid`, `train_taken`, `train_pc` and `suppress_count` are all zero.
- R2: One cycle after every accepted resolution, `train_valid` is 1, `train_taken` equals the resolved direction (1 = taken, i.e. the value was mispredicted) and `train_pc` equals `res_pc`. Tolerated cases are trained too.
- R3: For an ordinary branch (`res_tolerant`=0) whose resolved direction differs from its predicted direction, `flush` is 1 one cycle later. `redirect_pc` then equals `taken_target` if resolved taken, else `fallthru_target`.
- R4: A resolution whose resolved direction equals its predicted direction, of either kind, gives `flush`=0 and `redirect_pc`=0 one cycle later.
- R5: A tolerant branch predicted taken (1) and resolved not taken (0) gives `flush`=0 and `redirect_pc`=0 one cycle later, and `suppress_count` rises by one on that same cycle.
- R6: A tolerant branch predicted not taken (0) and resolved taken (1) gives `flush`=1 with `redirect_pc`=`taken_target` one cycle later.
- R7: `suppress_count` holds at 2^CNT_W-1 once reached and never wraps. Only the case of R5 changes it.
- R8: On a cycle with `res_valid`=0, all other resolution inputs are ignored. One cycle later `flush` and `train_valid` are 0, and `suppress_count` is unchanged.
- R9: `flush` is a single-cycle pulse for each recovering resolution. It drops on the following cycle unless another recovering resolution was accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Resolution strobe, one branch per cycle |
| res_tolerant | input | 1 | Branch is misprediction tolerant |
| pred_taken | input | 1 | Direction fetch followed |
| actual_taken | input | 1 | Resolved direction (1 = value wrong) |
| res_pc | input | ADDR_W | Address of the resolving branch |
| taken_target | input | ADDR_W | Fixup path address |
| fallthru_target | input | ADDR_W | Value-speculative path address |
| flush | output | 1 | Pipeline flush pulse |
| redirect_pc | output | ADDR_W | Fetch target while flush is high, else zero |
| train_valid | output | 1 | Predictor update strobe |
| train_taken | output | 1 | Direction to train |
| train_pc | output | ADDR_W | Branch address to train |
| suppress_count | output | CNT_W | Saturating count of tolerated mispredictions |

## Verification
The assertions assume that the inputs are known whenever `res_valid` is high and that at most one branch resolves per cycle. They assume nothing about the inputs while the strobe is low. The stimulus changes inputs only on the falling edge and holds each resolution for exactly one cycle. During idle cycles it deliberately drives arbitrary direction, flag and address values, so that the hold-off of R8 is exercised. The counter is driven past its ceiling with a run of back-to-back tolerated cases, and recovering branches are issued back to back to exercise the pulse rule of R9.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

  typedef enum logic [1:0] {
    RES_AGREE     = 2'd0,
    RES_RECOVER   = 2'd1,
    RES_TOLERATED = 2'd2
  } res_kind_e;

  // Classification of a resolved branch from its flags.
  function automatic res_kind_e judge(input logic tolerant,
                                      input logic pred,
                                      input logic act);
    if (pred == act) return RES_AGREE;
    if (tolerant && pred && !act) return RES_TOLERATED;
    return RES_RECOVER;
  endfunction

endpackage

// File: rtl/tbr_classify.sv
module tbr_classify
  import tbr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic tolerant,
  input  logic pred,
  input  logic act,
  output logic recover_ev,
  output logic tolerate_ev
);

  res_kind_e kind;

  always_comb begin
    kind        = judge(tolerant, pred, act);
    recover_ev  = valid && (kind == RES_RECOVER);
    tolerate_ev = valid && (kind == RES_TOLERATED);
  end

  // R6
  wrong_value_recovers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !pred && act) |-> recover_ev);

  // R4
  agree_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && (pred == act)) |-> (!recover_ev && !tolerate_ev));

endmodule

// File: rtl/tbr_sat_counter.sv
module tbr_sat_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return (v == TOP) ? v : v + 1'b1;
  endfunction

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else if (inc) count_q <= bump(count_q);
  end

  assign count = count_q;

  // R7
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == TOP) |=> (count_q == TOP));

  // R7
  cnt_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count_q));

endmodule

// File: rtl/tolerant_branch_resolver.sv
module tolerant_branch_resolver #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic              res_tolerant,
  input  logic              pred_taken,
  input  logic              actual_taken,
  input  logic [ADDR_W-1:0] res_pc,
  input  logic [ADDR_W-1:0] taken_target,
  input  logic [ADDR_W-1:0] fallthru_target,
  output logic              flush,
  output logic [ADDR_W-1:0] redirect_pc,
  output logic              train_valid,
  output logic              train_taken,
  output logic [ADDR_W-1:0] train_pc,
  output logic [CNT_W-1:0]  suppress_count
);

  logic recover_ev;
  logic tolerate_ev;

  tbr_classify u_cls (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid       (res_valid),
    .tolerant    (res_tolerant),
    .pred        (pred_taken),
    .act         (actual_taken),
    .recover_ev  (recover_ev),
    .tolerate_ev (tolerate_ev)
  );

  tbr_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (tolerate_ev),
    .count (suppress_count)
  );

  logic [ADDR_W-1:0] next_target;
  assign next_target = actual_taken ? taken_target : fallthru_target;

  logic              flush_q;
  logic [ADDR_W-1:0] redirect_q;
  logic              tv_q;
  logic              tt_q;
  logic [ADDR_W-1:0] tpc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_q    <= 1'b0;
      redirect_q <= '0;
      tv_q       <= 1'b0;
      tt_q       <= 1'b0;
      tpc_q      <= '0;
    end else begin
      flush_q    <= recover_ev;
      redirect_q <= recover_ev ? next_target : '0;
      tv_q       <= res_valid;
      tt_q       <= res_valid && actual_taken;
      tpc_q      <= res_valid ? res_pc : '0;
    end
  end

  assign flush       = flush_q;
  assign redirect_pc = redirect_q;
  assign train_valid = tv_q;
  assign train_taken = tt_q;
  assign train_pc    = tpc_q;

  // R3
  plain_mismatch_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_tolerant && (pred_taken != actual_taken)) |=> flush);

  // R5
  tolerated_no_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_tolerant && pred_taken && !actual_taken) |=> (!flush && redirect_pc == '0));

  // R2
  train_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (train_valid && train_taken == $past(actual_taken) && train_pc == $past(res_pc)));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> (!flush && !train_valid));

  // R9
  flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !recover_ev) |=> !flush);

endmodule

// File: tb/tolerant_branch_resolver_test.sv
`timescale 1ns/1ps
module tolerant_branch_resolver_test;

  localparam int AW = 32;
  localparam int CW = 4;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          res_valid = 1'b0, res_tolerant = 1'b0, pred_taken = 1'b0, actual_taken = 1'b0;
  logic [AW-1:0] res_pc = '0, taken_target = '0, fallthru_target = '0;
  logic          flush, train_valid, train_taken;
  logic [AW-1:0] redirect_pc, train_pc;
  logic [CW-1:0] suppress_count;

  always #2 clk = ~clk;

  tolerant_branch_resolver #(.ADDR_W(AW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_tolerant(res_tolerant),
    .pred_taken(pred_taken), .actual_taken(actual_taken), .res_pc(res_pc),
    .taken_target(taken_target), .fallthru_target(fallthru_target),
    .flush(flush), .redirect_pc(redirect_pc), .train_valid(train_valid),
    .train_taken(train_taken), .train_pc(train_pc), .suppress_count(suppress_count)
  );

  typedef struct {
    logic          fl;
    logic [AW-1:0] rd;
    logic          tv;
    logic          tt;
    logic [AW-1:0] tp;
    logic [CW-1:0] cnt;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  logic [CW-1:0] model_cnt = '0;
  bit running = 1'b0;

  task automatic check(input string tag, input string what, input logic [AW-1:0] act, input logic [AW-1:0] ex);
    checks++;
    if (act !== ex) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, ex);
    end
  endtask

  // Driver: one cycle per call, pushes the expectation for the next edge.
  task automatic step(input bit v, input bit tol, input bit p, input bit a,
                      input logic [AW-1:0] pc, input logic [AW-1:0] tt,
                      input logic [AW-1:0] ft, input string tag);
    exp_t e;
    @(negedge clk);
    res_valid = v; res_tolerant = tol; pred_taken = p; actual_taken = a;
    res_pc = pc; taken_target = tt; fallthru_target = ft;
    e.fl = v && (p != a) && !(tol && p && !a);
    e.rd = e.fl ? (a ? tt : ft) : '0;
    e.tv = v;
    e.tt = v && a;
    e.tp = v ? pc : '0;
    if (v && tol && p && !a && model_cnt != CMAX) model_cnt = model_cnt + 1'b1;
    e.cnt = model_cnt;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor
  always @(posedge clk) begin
    #1;
    if (running && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, "flush", AW'(flush), AW'(e.fl));
      check(e.tag, "redirect_pc", redirect_pc, e.rd);
      check(e.tag, "train_valid", AW'(train_valid), AW'(e.tv));
      check(e.tag, "train_taken", AW'(train_taken), AW'(e.tt));
      check(e.tag, "train_pc", train_pc, e.tp);
      check(e.tag, "suppress_count", AW'(suppress_count), AW'(e.cnt));
    end
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, with inputs active
    res_valid = 1'b1; pred_taken = 1'b0; actual_taken = 1'b1; res_pc = 32'h55;
    @(negedge clk);
    check("R1", "flush", AW'(flush), '0);
    check("R1", "train_valid", AW'(train_valid), '0);
    check("R1", "redirect_pc", redirect_pc, '0);
    check("R1", "suppress_count", AW'(suppress_count), '0);
    res_valid = 1'b0;
    rst_n = 1'b1;
    running = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, "R1_idle");
    // R3 ordinary mismatches, both directions
    step(1, 0, 0, 1, 32'h100, 32'hA000, 32'hB000, "R3_nt_to_t");
    step(0, 0, 0, 0, 0, 0, 0, "R9_drop");
    step(1, 0, 1, 0, 32'h104, 32'hA100, 32'hB100, "R3_t_to_nt");
    // R9 back-to-back recoveries
    step(1, 0, 1, 0, 32'h108, 32'hA200, 32'hB200, "R9_b2b_a");
    step(1, 1, 0, 1, 32'h10C, 32'hA300, 32'hB300, "R6_b2b_b");
    step(0, 1, 1, 0, 32'hFFF, 32'h1, 32'h2, "R9_then_idle");
    // R4 agreeing directions, both kinds
    step(1, 0, 0, 0, 32'h110, 32'hA400, 32'hB400, "R4_plain_nt");
    step(1, 0, 1, 1, 32'h114, 32'hA500, 32'hB500, "R4_plain_t");
    step(1, 1, 0, 0, 32'h118, 32'hA600, 32'hB600, "R4_tol_nt");
    step(1, 1, 1, 1, 32'h11C, 32'hA700, 32'hB700, "R4_tol_t");
    // R5 tolerated, R2 still trained
    step(1, 1, 1, 0, 32'h120, 32'hA800, 32'hB800, "R5_tolerated");
    // R6 tolerant but value wrong
    step(1, 1, 0, 1, 32'h124, 32'hA900, 32'hB900, "R6_recover");
    // R8 idle with noisy inputs
    step(0, 1, 1, 0, 32'hDEAD, 32'hBEEF, 32'hCAFE, "R8_noise_a");
    step(0, 0, 0, 1, 32'h1234, 32'h5678, 32'h9ABC, "R8_noise_b");
    // R7 saturation
    for (int i = 0; i < 20; i++)
      step(1, 1, 1, 0, 32'h200 + i, 32'hC000, 32'hD000, "R7_sat");
    step(1, 0, 0, 1, 32'h300, 32'hE000, 32'hF000, "R2_after_sat");
    step(0, 0, 0, 0, 0, 0, 0, "R7_hold");
    step(0, 0, 0, 0, 0, 0, 0, "R9_final");
    @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule